// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status and Coalescing Unit

This unit gathers ten single-cycle event pulses from an Ethernet MAC into a sticky status register. Software clears each status bit by writing a one to it. A mask register selects which status bits may drive the single interrupt line. Software reads and writes the three registers through a small word-addressed bus. Reads are combinational and writes take effect at the clock edge.

Two of the events, receive-complete and transmit-complete, are coalesced. Each of these two directions has a small event counter and a timeout timer. The direction's status bit rises on whichever comes first: the programmed number of events has been counted, or a programmed number of time units has passed since the first counted event. A time unit is a fixed span of time. The speed input picks its base length (100 Mbps or 10 Mbps), and a per-direction select bit makes it sixteen times longer. All unit lengths come from a prescaler, and the clock frequency is a parameter.

Top module: `mac_irq_coalesce`

## Requirements
- R1: After reset, the status register reads 0, the mask register reads 0, the coalescing control register reads 0x1010 (threshold 1 and timeout 0 for both directions), and `irq` is low.
- R2: A pulse on any non-coalesced event input (bits 1, 2, 3, 5, 6, 7, 8, 9) sets the matching status bit at the next clock edge. A set status bit stays set until software clears it.
- R3: Writing the status register (address 0) clears each bit written as 1 and leaves each bit written as 0 unchanged. An event in the same cycle as the clear of its bit wins, so the bit stays set.
- R4: `irq` is high exactly when some status bit and its mask bit (address 1, bits 9:0) are both 1.
- R5: The receive-OK status bit (bit 0) rises at the clock edge that samples the Nth counted receive event. The transmit-OK status bit (bit 4) does the same for transmit events. N is that direction's 3-bit threshold, and a threshold of 0 acts as 1.
- R6: When a direction's timeout T is nonzero, its status bit rises T time units after the edge that counted the first pending event, even if the threshold has not been reached.
- R7: A timeout of 0 turns the timer off, so only the threshold can raise the coalesced status bit.
- R8: The time unit is 5.12 us when `speed100` is 1 and 51.2 us when it is 0. With the long-unit bit set it becomes 81.92 us and 819.2 us. This is 640, 6400, 10240 and 102400 cycles of a 125 MHz clock.
- R9: While a coalesced status bit is set, events of that direction are not counted. Counting and timing start fresh once software clears the bit.
- R10: The coalescing control register (address 2) holds the receive timeout in bits 3:0, the receive threshold in bits 6:4, the receive long-unit bit in bit 7, the transmit timeout in bits 11:8, the transmit threshold in bits 14:12 and the transmit long-unit bit in bit 15. It reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register word address: 0 status, 1 mask, 2 coalescing control |
| busWrite | input | 1 | Write strobe for the addressed register |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Combinational read data of the addressed register |
| evtIn | input | 10 | Event pulses, one per status bit |
| speed100 | input | 1 | 1 selects the 100 Mbps time unit, 0 the 10 Mbps one |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches the status register on every cycle. It checks that status bits are sticky, that plain events set their bits at the next edge, that a status write clears only the bits written as one, that an all-zero mask keeps the line low, and that the receive bit never rises with the timer off and no receive event present. The count of events needed to fire, the exact cycle at which a timeout fires under each unit length, and the discarding of events that arrive while a coalesced bit is set depend on a history of many cycles. Only the bench's directed scenarios show these, by sampling the status register at computed cycles.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int EVT_W = 10;
  localparam int REG_W = 16;
  localparam int RX_OK_BIT = 0;
  localparam int TX_OK_BIT = 4;
  localparam int N_DIR = 2;
  localparam int CFG_W = REG_W / N_DIR;
  localparam logic [REG_W-1:0] COAL_RESET = 16'h1010;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_MASK   = 2'd1,
    ADDR_COAL   = 2'd2,
    ADDR_SPARE  = 2'd3
  } regAddr_e;

  // per-direction coalescing fields, bit order matches the register byte
  typedef struct packed {
    logic       longUnit;
    logic [2:0] thr;
    logic [3:0] tmo;
  } coalCfg_t;

  typedef struct packed {
    logic             wrStatus;
    logic             wrMask;
    logic             wrCoal;
    logic [REG_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/isc_control.sv
module isc_control
  import isc_pkg::*;
(
  input  logic [1:0]       busAddr,
  input  logic             busWrite,
  input  logic [REG_W-1:0] busWData,
  output regStrobe_t       strobe
);
  always_comb begin
    strobe = '0;
    strobe.data = busWData;
    if (busWrite) begin
      unique case (regAddr_e'(busAddr))
        ADDR_STATUS: strobe.wrStatus = 1'b1;
        ADDR_MASK:   strobe.wrMask = 1'b1;
        ADDR_COAL:   strobe.wrCoal = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/isc_coalesce.sv
module isc_coalesce
  import isc_pkg::*;
#(
  parameter int CLK_KHZ = 125000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     evt,
  input  coalCfg_t cfg,
  input  logic     speed100,
  input  logic     statusBit,
  output logic     fire
);
  // 5.12 us base unit expressed in clock cycles
  localparam int UNIT_BASE = (CLK_KHZ * 512) / 100000;
  localparam int UNIT_MAX  = UNIT_BASE * 160;
  localparam int PRE_W     = $clog2(UNIT_MAX + 1);

  logic [2:0]       cnt;
  logic [3:0]       units;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] unitLen;
  logic [3:0]       thrEff;
  logic             pending;
  logic             timerOn;
  logic             tick;
  logic             cntFire;
  logic             tmoFire;

  always_comb begin
    unique case ({cfg.longUnit, speed100})
      2'b01:   unitLen = PRE_W'(UNIT_BASE);
      2'b00:   unitLen = PRE_W'(UNIT_BASE * 10);
      2'b11:   unitLen = PRE_W'(UNIT_BASE * 16);
      default: unitLen = PRE_W'(UNIT_BASE * 160);
    endcase
  end

  assign thrEff  = (cfg.thr == 3'd0) ? 4'd1 : {1'b0, cfg.thr};
  assign pending = (cnt != 3'd0);
  assign timerOn = pending && (cfg.tmo != 4'd0);
  assign tick    = timerOn && (pre >= unitLen - PRE_W'(1));
  assign cntFire = evt && (({1'b0, cnt} + 4'd1) >= thrEff);
  assign tmoFire = tick && (({1'b0, units} + 5'd1) >= {1'b0, cfg.tmo});
  assign fire    = !statusBit && (cntFire || tmoFire);

  always_ff @(posedge clk) begin
    if (!rstN || statusBit || fire) begin
      cnt   <= '0;
      units <= '0;
      pre   <= '0;
    end else begin
      if (evt && cnt != 3'd7) cnt <= cnt + 3'd1;
      if (timerOn) begin
        if (tick) begin
          pre   <= '0;
          units <= units + 4'd1;
        end else begin
          pre <= pre + PRE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/isc_datapath.sv
module isc_datapath
  import isc_pkg::*;
#(
  parameter int CLK_KHZ = 125000
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [1:0]       rdAddr,
  input  logic [EVT_W-1:0] evtIn,
  input  logic             speed100,
  output logic [REG_W-1:0] rdData,
  output logic [EVT_W-1:0] statusQ,
  output logic [EVT_W-1:0] maskQ,
  output logic [REG_W-1:0] coalQ,
  output logic             irq
);
  logic [EVT_W-1:0] setVec;
  logic [EVT_W-1:0] clrVec;
  logic [N_DIR-1:0] fireVec;

  for (genvar b = 0; b < EVT_W; b++) begin : g_plain
    if (b != RX_OK_BIT && b != TX_OK_BIT) begin : g_direct
      assign setVec[b] = evtIn[b];
    end
  end

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    localparam int BIT_POS = (d == 0) ? RX_OK_BIT : TX_OK_BIT;
    coalCfg_t cfg;
    assign cfg = coalCfg_t'(coalQ[d*CFG_W +: CFG_W]);
    isc_coalesce #(.CLK_KHZ(CLK_KHZ)) u_coal (
      .clk       (clk),
      .rstN      (rstN),
      .evt       (evtIn[BIT_POS]),
      .cfg       (cfg),
      .speed100  (speed100),
      .statusBit (statusQ[BIT_POS]),
      .fire      (fireVec[d])
    );
    assign setVec[BIT_POS] = fireVec[d];
  end

  assign clrVec = strobe.wrStatus ? strobe.data[EVT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      coalQ   <= COAL_RESET;
    end else begin
      statusQ <= (statusQ & ~clrVec) | setVec;
      if (strobe.wrMask) maskQ <= strobe.data[EVT_W-1:0];
      if (strobe.wrCoal) coalQ <= strobe.data;
    end
  end

  assign irq = |(statusQ & maskQ);

  always_comb begin
    unique case (regAddr_e'(rdAddr))
      ADDR_STATUS: rdData = REG_W'(statusQ);
      ADDR_MASK:   rdData = REG_W'(maskQ);
      ADDR_COAL:   rdData = coalQ;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/mac_irq_coalesce.sv
module mac_irq_coalesce
  import isc_pkg::*;
#(
  parameter int CLK_KHZ = 125000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWrite,
  input  logic [REG_W-1:0] busWData,
  output logic [REG_W-1:0] busRData,
  input  logic [EVT_W-1:0] evtIn,
  input  logic             speed100,
  output logic             irq
);
  regStrobe_t       strobe;
  logic [EVT_W-1:0] statusVec;
  logic [EVT_W-1:0] maskVec;
  logic [REG_W-1:0] coalVec;

  isc_control u_ctl (
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busWData (busWData),
    .strobe   (strobe)
  );

  isc_datapath #(.CLK_KHZ(CLK_KHZ)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdAddr   (busAddr),
    .evtIn    (evtIn),
    .speed100 (speed100),
    .rdData   (busRData),
    .statusQ  (statusVec),
    .maskQ    (maskVec),
    .coalQ    (coalVec),
    .irq      (irq)
  );
endmodule

// File: rtl/mac_irq_coalesce_chk.sv
module mac_irq_coalesce_chk
  import isc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       busAddr,
  input logic             busWrite,
  input logic [EVT_W-1:0] wData,
  input logic [EVT_W-1:0] evtIn,
  input logic [EVT_W-1:0] statusVec,
  input logic [EVT_W-1:0] maskVec,
  input logic [3:0]       rxTmo,
  input logic             irq
);
  localparam logic [EVT_W-1:0] PLAIN = ~((EVT_W'(1) << RX_OK_BIT) | (EVT_W'(1) << TX_OK_BIT));

  logic             clrNow;
  logic [EVT_W-1:0] keepVec;
  logic [EVT_W-1:0] dropVec;

  assign clrNow  = busWrite && (busAddr == 2'd0);
  assign keepVec = statusVec & ~(clrNow ? wData : '0);
  assign dropVec = clrNow ? (wData & statusVec & ~evtIn) : '0;

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusVec & $past(keepVec)) == $past(keepVec)));

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusVec & $past(evtIn & PLAIN)) == $past(evtIn & PLAIN)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    clrNow |=> ((statusVec & $past(dropVec)) == '0));

  assert_mask_gates_R4: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> !irq);

  assert_no_timer_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxTmo == 4'd0 && !evtIn[RX_OK_BIT] && !statusVec[RX_OK_BIT]) |=> !statusVec[RX_OK_BIT]);
endmodule

bind mac_irq_coalesce mac_irq_coalesce_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrite  (busWrite),
  .wData     (busWData[9:0]),
  .evtIn     (evtIn),
  .statusVec (statusVec),
  .maskVec   (maskVec),
  .rxTmo     (coalVec[3:0]),
  .irq       (irq)
);

// File: tb/mac_irq_coalesce_tb.sv
module mac_irq_coalesce_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic        busWrite = 1'b0;
  logic [15:0] busWData = 16'h0;
  logic [15:0] busRData;
  logic [9:0]  evtIn = 10'h0;
  logic        speed100 = 1'b1;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mac_irq_coalesce u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWData(busWData), .busRData(busRData), .evtIn(evtIn),
    .speed100(speed100), .irq(irq)
  );

  typedef struct packed {
    logic [9:0]  evt;
    logic        wr;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [9:0]  expStatus;
    logic        expIrq;
  } vec_t;

  // default control: threshold 1, timeout 0, so bits 0 and 4 fire per event
  localparam vec_t VECS [13] = '{
    '{10'h002, 1'b0, 2'd0, 16'h0000, 10'h002, 1'b0}, // R2 plain set, mask 0 (R4)
    '{10'h000, 1'b1, 2'd1, 16'h03FF, 10'h002, 1'b1}, // R4 unmask
    '{10'h201, 1'b0, 2'd0, 16'h0000, 10'h203, 1'b1}, // R5 rx thr 1, R2 bit 9
    '{10'h000, 1'b1, 2'd0, 16'h0003, 10'h200, 1'b1}, // R3 clear two bits
    '{10'h200, 1'b1, 2'd0, 16'h0200, 10'h200, 1'b1}, // R3 set wins
    '{10'h000, 1'b1, 2'd0, 16'h0200, 10'h000, 1'b0}, // R3 clear last
    '{10'h010, 1'b0, 2'd0, 16'h0000, 10'h010, 1'b1}, // R5 tx thr 1
    '{10'h000, 1'b1, 2'd1, 16'h000F, 10'h010, 1'b0}, // R4 bit 4 masked
    '{10'h1EC, 1'b0, 2'd0, 16'h0000, 10'h1FC, 1'b1}, // R2 many bits
    '{10'h000, 1'b1, 2'd0, 16'h03FF, 10'h000, 1'b0}, // R3 clear all
    '{10'h100, 1'b1, 2'd0, 16'h0000, 10'h100, 1'b0}, // R3 zero write no effect
    '{10'h000, 1'b1, 2'd1, 16'h0100, 10'h100, 1'b1}, // R4 unmask bit 8
    '{10'h000, 1'b1, 2'd0, 16'h0100, 10'h000, 1'b0}  // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrite = 1'b1; busWData = d;
    @(posedge clk); #1;
    busWrite = 1'b0; busAddr = 2'd0;
  endtask

  task automatic pulse(input logic [9:0] e);
    @(negedge clk);
    evtIn = e;
    @(posedge clk); #1;
    evtIn = 10'h0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] v);
    busAddr = a; #1;
    v = busRData;
    busAddr = 2'd0;
  endtask

  task automatic statusBit(input string req, input int b, input logic exp);
    logic [15:0] v;
    readReg(2'd0, v);
    check(req, {31'b0, v[b]}, {31'b0, exp});
  endtask

  task automatic timeoutCase(input string req, input logic [15:0] ctrl, input logic spd,
                             input logic [9:0] e, input int b, input int cyc);
    regWrite(2'd2, ctrl);
    speed100 = spd;
    regWrite(2'd0, 16'h03FF);
    pulse(e);
    repeat (cyc - 1) @(posedge clk);
    #1 statusBit(req, b, 1'b0);
    @(posedge clk);
    #1 statusBit(req, b, 1'b1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1 reset state
    readReg(2'd0, v); check("R1 status", v, 16'h0);
    readReg(2'd1, v); check("R1 mask", v, 16'h0);
    readReg(2'd2, v); check("R1 ctrl", v, 16'h1010);
    check("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      evtIn = VECS[i].evt; busWrite = VECS[i].wr;
      busAddr = VECS[i].addr; busWData = VECS[i].wdata;
      @(posedge clk); #1;
      evtIn = 10'h0; busWrite = 1'b0; busAddr = 2'd0;
      #1;
      check($sformatf("R2/R3/R4 vector %0d status", i), {22'b0, busRData[9:0]}, {22'b0, VECS[i].expStatus});
      check($sformatf("R4 vector %0d irq", i), {31'b0, irq}, {31'b0, VECS[i].expIrq});
    end

    regWrite(2'd1, 16'h03FF);
    // R5 rx threshold 3, R10 field position
    regWrite(2'd2, 16'h1030);
    readReg(2'd2, v); check("R10 ctrl readback", v, 16'h1030);
    pulse(10'h001); pulse(10'h001);
    statusBit("R5 rx below threshold", 0, 1'b0);
    pulse(10'h001);
    statusBit("R5 rx third event", 0, 1'b1);
    check("R4 irq after rx", {31'b0, irq}, 32'h1);
    // R9 events while set are not counted
    pulse(10'h001); pulse(10'h001);
    regWrite(2'd0, 16'h0001);
    pulse(10'h001); pulse(10'h001);
    statusBit("R9 fresh count after clear", 0, 1'b0);
    pulse(10'h001);
    statusBit("R9 fires on third fresh event", 0, 1'b1);
    // R5 threshold 0 acts as 1 (tx)
    regWrite(2'd2, 16'h0030);
    regWrite(2'd0, 16'h03FF);
    pulse(10'h010);
    statusBit("R5 tx threshold 0", 4, 1'b1);

    // R6 R8 timeouts: rx thr 7
    timeoutCase("R6 rx tmo 2 fast", 16'h1072, 1'b1, 10'h001, 0, 1280);
    timeoutCase("R8 rx slow unit", 16'h1071, 1'b0, 10'h001, 0, 6400);
    timeoutCase("R8 rx long fast unit", 16'h10F1, 1'b1, 10'h001, 0, 10240);
    timeoutCase("R10 tx timeout field", 16'h7170, 1'b1, 10'h010, 4, 640);

    // R7 timeout 0: only threshold
    regWrite(2'd2, 16'h1070);
    regWrite(2'd0, 16'h03FF);
    pulse(10'h001);
    repeat (12000) @(posedge clk);
    #1 statusBit("R7 no timer with tmo 0", 0, 1'b0);
    for (int k = 0; k < 5; k++) pulse(10'h001);
    statusBit("R7 six events below thr 7", 0, 1'b0);
    pulse(10'h001);
    statusBit("R5 seventh event fires", 0, 1'b1);

    finishRun();
  end
endmodule